// File: doc/BRIEF.md
# Device-Paced Channel Word Sequencer

This block moves a single word of a device-paced read or write transfer through its address step. Every device on the channel has a request flip-flop that its controller sets when it is ready. When the sequencer is idle it picks one pending device and raises a high-speed request to the I/O processor. It then waits for the processor's data-poll grant. After the grant it reloads that device's saved context from a small per-device RAM. The context holds a state field, a memory address, an auxiliary (bank) value and a word count.

On the presentation cycle the sequencer drives the address onto the data-out lines and the auxiliary value onto the extension lines. In the same cycle it raises service-in and sends a direction command: to memory for input transfers, from memory for output transfers. The address step is the same for both directions. In that cycle the sequencer also clears the device's request flip-flop, and the address and the word count (a negative count that counts up) are each incremented. On the next cycle the updated context is written back to RAM, and the block accepts a new request only after that.

When the incremented count reaches zero, a terminal-count flag is raised and the context's armed bit is cleared. Any later request from that device is then drained without a transfer. The context RAM is loaded through a write port, which stands in for the earlier program-word phase.

Top module: `wordxfer_seq`

## Requirements
- R1: While reset is held and directly after it, hsReq, svcIn, svcClr, busy and termCount are all 0 and ioCmd is 2'b00.
- R2: A request pending while the block is idle raises hsReq one cycle later, and hsReq stays high until the cycle after dataPoll is sampled high.
- R3: When several requests are pending together, the device with the lowest index is served first.
- R4: Exactly two cycles after dataPoll is sampled in the request phase, svcIn is high for one cycle, with dataOut equal to the stored address and extOut equal to the stored auxiliary value.
- R5: ioCmd is 2'b01 (to memory) when the context's direction bit cfgState[0] is 1, and 2'b10 (from memory) when it is 0. ioCmd, dataOut and extOut are all zero whenever svcIn is low.
- R6: In the presentation cycle svcClr is one-hot on the served device's bit. This also holds for an unarmed device.
- R7: After each word the address and the count are incremented and written back, so the next word from the same device presents address+1. The address wraps modulo 2^AW.
- R8: termCount updates in the cycle after svcIn. It goes to 1 when the incremented count is zero, and otherwise holds until the next transferred word. A zero count clears the armed bit cfgState[1] in the written-back context.
- R9: A context whose armed bit cfgState[1] is 0 produces no svcIn and no increment. Its request is still cleared, and termCount does not change.
- R10: busy is high from the request phase through writeback. A request that arrives while busy is held off and is served only after the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| svcReq | input | NDEV | Per-device request flip-flop states |
| svcClr | output | NDEV | One-cycle clear pulse for the served device's request flip-flop |
| hsReq | output | 1 | High-speed request to the I/O processor |
| dataPoll | input | 1 | Data-poll grant from the I/O processor |
| svcIn | output | 1 | Service-in strobe marking a presented address |
| dataOut | output | AW | Memory address lines |
| extOut | output | XW | Auxiliary (bank) extension lines |
| ioCmd | output | 2 | Direction command: 01 to memory, 10 from memory, 00 none |
| termCount | output | 1 | Word count reached zero on the last word |
| busy | output | 1 | Sequencer is out of idle |
| cfgWe | input | 1 | Context write enable |
| cfgDev | input | $clog2(NDEV) | Context entry to write |
| cfgState | input | 2 | Context state: bit 1 armed, bit 0 direction (1 = to memory) |
| cfgAddr | input | AW | Context start address |
| cfgAux | input | XW | Context auxiliary value |
| cfgCount | input | CW | Context word count, negative and counting up |

## Verification
On every cycle the assertions check the following. The command and address lines stay quiet outside service-in. The clear pulse is one-hot and coincides with service-in. Service-in lasts one cycle and always comes two cycles after a poll grant. termCount changes only just after a presentation. Which device is chosen, the incremented and wrapped address seen on the following word, the terminal-count effect on the armed bit, and holding off requests while busy all depend on state stored across several transfers. Only the bench's scenarios can show these.

// File: rtl/wxs_pkg.sv
package wxs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_FETCH,
    S_SEND,
    S_WB
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCtx;
    logic advance;
    logic writeBack;
    logic present;
  } dpStrobe_t;

  localparam logic [1:0] CMD_NONE     = 2'b00;
  localparam logic [1:0] CMD_TO_MEM   = 2'b01;
  localparam logic [1:0] CMD_FROM_MEM = 2'b10;

endpackage

// File: rtl/wxs_ctrl.sv
module wxs_ctrl
  import wxs_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int DW   = $clog2(NDEV)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NDEV-1:0] svcReq,
  input  logic            dataPoll,
  input  logic            ctxArmed,
  output dpStrobe_t       strobe,
  output logic [DW-1:0]   devSel,
  output logic            hsReq,
  output logic            busy,
  output logic [NDEV-1:0] svcClr
);

  seqState_e state;
  logic [NDEV-1:0] grant;
  logic [DW-1:0]   pickIdx;
  logic            anyReq;

  // lowest index wins
  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < NDEV; i++) begin
      grant[i] = svcReq[i] & ~seen;
      seen     = seen | svcReq[i];
    end
    anyReq = seen;
  end

  always_comb begin
    pickIdx = '0;
    for (int i = 0; i < NDEV; i++)
      if (grant[i]) pickIdx = pickIdx | DW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      devSel <= '0;
    end else begin
      unique case (state)
        S_IDLE:  if (anyReq) begin
                   state  <= S_REQ;
                   devSel <= pickIdx;
                 end
        S_REQ:   if (dataPoll) state <= S_FETCH;
        S_FETCH: state <= S_SEND;
        S_SEND:  state <= ctxArmed ? S_WB : S_IDLE;
        S_WB:    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign hsReq            = (state == S_REQ);
  assign busy             = (state != S_IDLE);
  assign strobe.loadCtx   = (state == S_FETCH);
  assign strobe.present   = (state == S_SEND) && ctxArmed;
  assign strobe.advance   = (state == S_SEND) && ctxArmed;
  assign strobe.writeBack = (state == S_WB);

  for (genvar g = 0; g < NDEV; g++) begin : g_clr
    assign svcClr[g] = (state == S_SEND) && (devSel == DW'(g));
  end

endmodule

// File: rtl/wxs_datapath.sv
module wxs_datapath
  import wxs_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int DW   = $clog2(NDEV),
  parameter int AW   = 16,
  parameter int XW   = 4,
  parameter int CW   = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] devSel,
  input  logic          cfgWe,
  input  logic [DW-1:0] cfgDev,
  input  logic [1:0]    cfgState,
  input  logic [AW-1:0] cfgAddr,
  input  logic [XW-1:0] cfgAux,
  input  logic [CW-1:0] cfgCount,
  output logic          ctxArmed,
  output logic          svcIn,
  output logic [AW-1:0] dataOut,
  output logic [XW-1:0] extOut,
  output logic [1:0]    ioCmd,
  output logic          termCount
);

  localparam int CTXW = 2 + AW + XW + CW;

  logic [NDEV-1:0][CTXW-1:0] ctxMem;
  logic [1:0]    stateReg;
  logic [AW-1:0] addrReg;
  logic [XW-1:0] auxReg;
  logic [CW-1:0] cntReg;
  logic          tcReg;
  logic [CW-1:0] cntNext;
  logic [1:0]    wbState;

  assign cntNext = cntReg + CW'(1);
  assign wbState = {stateReg[1] & ~tcReg, stateReg[0]};

  // context RAM: writeback beats a config write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxMem <= '0;
    end else begin
      for (int i = 0; i < NDEV; i++) begin
        if (strobe.writeBack && devSel == DW'(i))
          ctxMem[i] <= {wbState, addrReg, auxReg, cntReg};
        else if (cfgWe && cfgDev == DW'(i))
          ctxMem[i] <= {cfgState, cfgAddr, cfgAux, cfgCount};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateReg <= '0;
      addrReg  <= '0;
      auxReg   <= '0;
      cntReg   <= '0;
      tcReg    <= 1'b0;
    end else if (strobe.loadCtx) begin
      {stateReg, addrReg, auxReg, cntReg} <= ctxMem[devSel];
    end else if (strobe.advance) begin
      addrReg <= addrReg + AW'(1);
      cntReg  <= cntNext;
      tcReg   <= (cntNext == '0);
    end
  end

  assign ctxArmed  = stateReg[1];
  assign svcIn     = strobe.present;
  assign dataOut   = strobe.present ? addrReg : '0;
  assign extOut    = strobe.present ? auxReg  : '0;
  assign ioCmd     = !strobe.present ? CMD_NONE :
                     (stateReg[0] ? CMD_TO_MEM : CMD_FROM_MEM);
  assign termCount = tcReg;

endmodule

// File: rtl/wordxfer_seq.sv
module wordxfer_seq
  import wxs_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int AW   = 16,
  parameter int XW   = 4,
  parameter int CW   = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NDEV-1:0]          svcReq,
  output logic [NDEV-1:0]          svcClr,
  output logic                     hsReq,
  input  logic                     dataPoll,
  output logic                     svcIn,
  output logic [AW-1:0]            dataOut,
  output logic [XW-1:0]            extOut,
  output logic [1:0]               ioCmd,
  output logic                     termCount,
  output logic                     busy,
  input  logic                     cfgWe,
  input  logic [$clog2(NDEV)-1:0]  cfgDev,
  input  logic [1:0]               cfgState,
  input  logic [AW-1:0]            cfgAddr,
  input  logic [XW-1:0]            cfgAux,
  input  logic [CW-1:0]            cfgCount
);

  localparam int DW = $clog2(NDEV);

  dpStrobe_t     strobe;
  logic [DW-1:0] devSel;
  logic          ctxArmed;

  wxs_ctrl #(.NDEV(NDEV), .DW(DW)) i_ctrl (
    .clk(clk), .rstN(rstN), .svcReq(svcReq), .dataPoll(dataPoll),
    .ctxArmed(ctxArmed), .strobe(strobe), .devSel(devSel),
    .hsReq(hsReq), .busy(busy), .svcClr(svcClr)
  );

  wxs_datapath #(.NDEV(NDEV), .DW(DW), .AW(AW), .XW(XW), .CW(CW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .devSel(devSel),
    .cfgWe(cfgWe), .cfgDev(cfgDev), .cfgState(cfgState),
    .cfgAddr(cfgAddr), .cfgAux(cfgAux), .cfgCount(cfgCount),
    .ctxArmed(ctxArmed), .svcIn(svcIn), .dataOut(dataOut),
    .extOut(extOut), .ioCmd(ioCmd), .termCount(termCount)
  );

endmodule

// File: rtl/wxs_checker.sv
module wxs_checker #(
  parameter int NDEV = 4,
  parameter int AW   = 16,
  parameter int XW   = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            hsReq,
  input logic            dataPoll,
  input logic            svcIn,
  input logic [NDEV-1:0] svcClr,
  input logic [1:0]      ioCmd,
  input logic [AW-1:0]   dataOut,
  input logic [XW-1:0]   extOut,
  input logic            termCount,
  input logic            busy
);

  p_quiet_lines_r5: assert property (@(posedge clk) disable iff (!rstN)
    !svcIn |-> (ioCmd == 2'b00 && dataOut == '0 && extOut == '0));

  p_cmd_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    svcIn |-> (ioCmd == 2'b01 || ioCmd == 2'b10));

  p_clear_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(svcClr));

  p_clear_with_svcin_r6: assert property (@(posedge clk) disable iff (!rstN)
    svcIn |-> ($countones(svcClr) == 1));

  p_poll_leads_svcin_r4: assert property (@(posedge clk) disable iff (!rstN)
    svcIn |-> ($past(dataPoll, 2) && !hsReq));

  p_svcin_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    svcIn |=> !svcIn);

  p_tc_moves_after_svcin_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(svcIn) |-> $stable(termCount));

  p_hsreq_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    hsReq |-> busy);

  p_no_req_during_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|svcClr) |-> !hsReq);

endmodule

bind wordxfer_seq wxs_checker #(.NDEV(NDEV), .AW(AW), .XW(XW)) i_chk (
  .clk(clk), .rstN(rstN), .hsReq(hsReq), .dataPoll(dataPoll),
  .svcIn(svcIn), .svcClr(svcClr), .ioCmd(ioCmd), .dataOut(dataOut),
  .extOut(extOut), .termCount(termCount), .busy(busy)
);

// File: tb/test_wordxfer_seq.sv
`timescale 1ns/1ps
module test_wordxfer_seq;

  localparam int NDEV = 4;
  localparam int AW   = 16;
  localparam int XW   = 4;
  localparam int CW   = 12;

  typedef struct packed {
    logic [1:0]    dev;
    logic [AW-1:0] addr;
    logic [XW-1:0] aux;
    logic [1:0]    cmd;
    logic          present;
    logic          tc;
  } vec_t;

  // walked in order; context preload below
  localparam vec_t VECS [7] = '{
    '{2'd0, 16'h1000, 4'h3, 2'b01, 1'b1, 1'b0},
    '{2'd1, 16'h2FFF, 4'h1, 2'b10, 1'b1, 1'b1},
    '{2'd0, 16'h1001, 4'h3, 2'b01, 1'b1, 1'b1},
    '{2'd2, 16'hFFFF, 4'h7, 2'b01, 1'b1, 1'b0},
    '{2'd2, 16'h0000, 4'h7, 2'b01, 1'b1, 1'b0},
    '{2'd1, 16'h0000, 4'h0, 2'b00, 1'b0, 1'b0},
    '{2'd3, 16'h0000, 4'h0, 2'b00, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NDEV-1:0] devFF;
  logic [NDEV-1:0] setPulse = '0;
  logic [NDEV-1:0] svcClr;
  logic hsReq, svcIn, termCount, busy;
  logic dataPoll = 1'b0;
  logic [AW-1:0] dataOut;
  logic [XW-1:0] extOut;
  logic [1:0] ioCmd;
  logic cfgWe = 1'b0;
  logic [1:0] cfgDev = '0;
  logic [1:0] cfgState = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic [XW-1:0] cfgAux = '0;
  logic [CW-1:0] cfgCount = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // device request flip-flops
  always_ff @(posedge clk) begin
    if (!rstN) devFF <= '0;
    else       devFF <= (devFF & ~svcClr) | setPulse;
  end

  wordxfer_seq #(.NDEV(NDEV), .AW(AW), .XW(XW), .CW(CW)) i_wordxfer_seq (
    .clk(clk), .rstN(rstN), .svcReq(devFF), .svcClr(svcClr), .hsReq(hsReq),
    .dataPoll(dataPoll), .svcIn(svcIn), .dataOut(dataOut), .extOut(extOut),
    .ioCmd(ioCmd), .termCount(termCount), .busy(busy), .cfgWe(cfgWe),
    .cfgDev(cfgDev), .cfgState(cfgState), .cfgAddr(cfgAddr),
    .cfgAux(cfgAux), .cfgCount(cfgCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadCtx(input int dev, input logic [1:0] st, input logic [AW-1:0] a,
                         input logic [XW-1:0] x, input logic [CW-1:0] c);
    @(negedge clk);
    cfgWe = 1'b1; cfgDev = 2'(dev); cfgState = st;
    cfgAddr = a; cfgAux = x; cfgCount = c;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic serviceWord(input logic [NDEV-1:0] mask, input vec_t v);
    logic [NDEV-1:0] expClr;
    expClr = NDEV'(1) << v.dev;
    if (mask != '0) begin
      setPulse = mask;
      @(negedge clk);
      setPulse = '0;
      check(hsReq == 1'b0, "R2", "hsReq before arbitration", 32'(hsReq), 0);
    end
    @(negedge clk);
    check(hsReq == 1'b1, "R2", "hsReq raised", 32'(hsReq), 1);
    check(busy == 1'b1, "R10", "busy in request phase", 32'(busy), 1);
    @(negedge clk);
    check(hsReq == 1'b1, "R2", "hsReq held without poll", 32'(hsReq), 1);
    dataPoll = 1'b1;
    @(negedge clk);
    dataPoll = 1'b0;
    check(hsReq == 1'b0, "R2", "hsReq dropped after poll", 32'(hsReq), 0);
    check(svcIn == 1'b0, "R4", "svcIn not yet", 32'(svcIn), 0);
    @(negedge clk);
    // presentation cycle
    check(svcIn == v.present, "R4", "svcIn", 32'(svcIn), 32'(v.present));
    check(dataOut == v.addr, "R7", "dataOut", 32'(dataOut), 32'(v.addr));
    check(extOut == v.aux, "R4", "extOut", 32'(extOut), 32'(v.aux));
    check(ioCmd == v.cmd, "R5", "ioCmd", 32'(ioCmd), 32'(v.cmd));
    check(svcClr == expClr, "R6", "svcClr", 32'(svcClr), 32'(expClr));
    @(negedge clk);
    check(svcIn == 1'b0, "R4", "svcIn single cycle", 32'(svcIn), 0);
    check(devFF[v.dev] == 1'b0, "R9", "request cleared", 32'(devFF), 0);
    check(termCount == v.tc, "R8", "termCount", 32'(termCount), 32'(v.tc));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values under reset
    check(hsReq == 0 && svcIn == 0 && busy == 0 && termCount == 0 && svcClr == 0 && ioCmd == 0,
          "R1", "outputs under reset", {hsReq, svcIn, busy, termCount, svcClr, ioCmd}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(hsReq == 0 && svcIn == 0 && busy == 0 && termCount == 0 && svcClr == 0 && ioCmd == 0,
          "R1", "outputs after reset", {hsReq, svcIn, busy, termCount, svcClr, ioCmd}, 0);

    loadCtx(0, 2'b11, 16'h1000, 4'h3, 12'hFFE);
    loadCtx(1, 2'b10, 16'h2FFF, 4'h1, 12'hFFF);
    loadCtx(2, 2'b11, 16'hFFFF, 4'h7, 12'hFFD);
    loadCtx(3, 2'b01, 16'h3000, 4'h2, 12'hFFC);

    // table: R4 R5 R7 R8 R9
    for (int i = 0; i < 7; i++) begin
      serviceWord(NDEV'(1) << VECS[i].dev, VECS[i]);
      check(busy == 1'b0, "R10", "idle after word", 32'(busy), 0);
    end

    // R3 priority, R10 hold-off of the losing request
    loadCtx(1, 2'b10, 16'h0400, 4'h2, 12'hFFC);
    loadCtx(3, 2'b11, 16'h0800, 4'h5, 12'hFFC);
    serviceWord(4'b1010, '{2'd1, 16'h0400, 4'h2, 2'b10, 1'b1, 1'b0});
    check(devFF == 4'b1000, "R10", "dev3 still pending", 32'(devFF), 32'h8);
    serviceWord(4'b0000, '{2'd3, 16'h0800, 4'h5, 2'b01, 1'b1, 1'b0});
    check(devFF == 4'b0000, "R3", "all requests served", 32'(devFF), 0);
    check(busy == 1'b0, "R10", "idle at end", 32'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule